// File: doc/BRIEF.md
# Audio Master Clock Ratio Generator

This block turns one fast audio core clock into the master clock (MCLK) for an external codec. It also produces the bit-clock and left/right-clock timing strobes for a serial audio port. The core clock runs at twice the base audio rate. The base audio rate is 512 times the sample rate (the core clock is then 1024fs) or 384 times the sample rate (the core clock is then 768fs), chosen by a base-select input.

A 3-bit divide code halves MCLK once per step, so MCLK equals the base clock divided by 2^code. Because the core clock is twice the base, even code 0 gives a registered, 50 % duty square wave. One LR frame covers one sample period and holds two channel slots. The bit-clock strobe fires 32 times per slot for words up to 16 bits, or 48 times per slot when the wide-slot input is set for 20-bit or 24-bit words. The strobes are spread as evenly as the frame length allows.

In slave mode the block stops generating its own strobes. It derives them instead from externally supplied bit and LR clock pins, through a synchroniser and edge detector. MCLK is still generated in slave mode.

Top module: `audio_mclk_gen`

## Requirements
- R1: While `run` is sampled low, `mclk`, `bclk_tick` and `lr_tick` are all 0 from the next cycle on, and the frame position returns to 0. Immediately after reset all three outputs are 0.
- R2: With `base384`=0 the frame is 1024 core cycles long. At frame position p (0..1023), with code c in 0..4, `mclk` equals bit c of p. This gives MCLK ratios of 512, 256, 128, 64 and 32 times fs.
- R3: With `base384`=1 the frame is 768 core cycles long. With code c in 0..3, `mclk` equals bit c of p. This gives MCLK ratios of 384, 192, 96 and 48 times fs.
- R4: Codes 5, 6 and 7 with `base384`=0, and codes 4 to 7 with `base384`=1, behave exactly like code 0.
- R5: In master mode, `bclk_tick` is 1 at position p exactly when (p*S) mod F < S. Here F is the frame length and S is 64 when `wide_slot`=0 or 96 when `wide_slot`=1. Each frame therefore carries S single-cycle strobes.
- R6: In master mode, `lr_tick` is 1 exactly at positions 0 and F/2, which are the starts of the two channel slots.
- R7: A change of `base384`, `mult_code` or `wide_slot` while running leaves the current frame unchanged. The new settings apply from position 0 of the next frame.
- R8: With `slave`=1, `bclk_tick` pulses for one cycle on each rising edge of `ext_bclk`, and `lr_tick` pulses for one cycle on each edge of `ext_lrclk`. If a pin changes just before core edge k, the pulse is visible after edge k+SYNC_STAGES-1, where SYNC_STAGES defaults to 2. No internally generated strobe appears in slave mode.
- R9: In master mode, activity on `ext_bclk` and `ext_lrclk` has no effect on any output.
- R10: The first cycle after `run` is first sampled high is frame position 0. The settings sampled on that same edge apply to that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the base audio rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables MCLK and strobe generation |
| base384 | input | 1 | 0: base is 512fs, 1: base is 384fs |
| mult_code | input | 3 | MCLK divide code, MCLK = base / 2^code |
| wide_slot | input | 1 | 1: 48 bit strobes per slot, 0: 32 |
| slave | input | 1 | 1: strobes come from the external pins |
| ext_bclk | input | 1 | External bit clock, asynchronous |
| ext_lrclk | input | 1 | External LR clock, asynchronous |
| mclk | output | 1 | Master clock output |
| bclk_tick | output | 1 | One-cycle bit-clock strobe |
| lr_tick | output | 1 | One-cycle channel-slot start strobe |

## Verification
The risky coincidence is a settings change that lands in the same cycle as the frame wrap. At that edge the divide select and the strobe accumulator both switch, and position 0 must already use the new settings. The bench changes the divide code, base select and slot width partway through a running frame. It then compares every cycle of the rest of that frame against the old arithmetic, and every cycle of the following frame against the new arithmetic. A select switch one cycle early or late shows up as a miscompare at position 0 or at the last position.

// File: rtl/amclk_pkg.sv
package amclk_pkg;
  localparam int AMC_CODE_W = 3;

  typedef struct packed {
    logic                  base384;
    logic [AMC_CODE_W-1:0] code;
    logic                  wide;
  } amc_cfg_t;
endpackage

// File: rtl/amclk_cfg_hold.sv
module amclk_cfg_hold
  import amclk_pkg::*;
#(
  parameter int MAX_CODE_512 = 4,
  parameter int MAX_CODE_384 = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  amc_cfg_t              cfg_in,
  output amc_cfg_t              cfg_q,
  output logic [AMC_CODE_W-1:0] eff_code
);
  localparam logic [AMC_CODE_W-1:0] LIM_512 = AMC_CODE_W'(MAX_CODE_512);
  localparam logic [AMC_CODE_W-1:0] LIM_384 = AMC_CODE_W'(MAX_CODE_384);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end

  // Codes beyond the top ratio of the selected base fall back to code 0
  always_comb begin
    if (cfg_q.code > (cfg_q.base384 ? LIM_384 : LIM_512)) eff_code = '0;
    else                                                   eff_code = cfg_q.code;
  end
endmodule

// File: rtl/amclk_frame_ctr.sv
module amclk_frame_ctr #(
  parameter int FRAME_512 = 1024,
  parameter int FRAME_384 = 768,
  parameter int POS_W     = $clog2(FRAME_512)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             base384,
  output logic             on_q,
  output logic [POS_W-1:0] pos,
  output logic             wrap,
  output logic             slot_start
);
  localparam logic [POS_W-1:0] LAST_512 = POS_W'(FRAME_512 - 1);
  localparam logic [POS_W-1:0] LAST_384 = POS_W'(FRAME_384 - 1);
  localparam logic [POS_W-1:0] HALF_512 = POS_W'(FRAME_512 / 2);
  localparam logic [POS_W-1:0] HALF_384 = POS_W'(FRAME_384 / 2);

  logic [POS_W-1:0] last_pos;
  logic [POS_W-1:0] half_pos;

  assign last_pos = base384 ? LAST_384 : LAST_512;
  assign half_pos = base384 ? HALF_384 : HALF_512;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
      pos  <= '0;
    end else begin
      on_q <= run;
      if (!run || !on_q)        pos <= '0;
      else if (pos == last_pos) pos <= '0;
      else                      pos <= pos + 1'b1;
    end
  end

  assign wrap       = on_q && (pos == last_pos);
  assign slot_start = on_q && ((pos == '0) || (pos == half_pos));
endmodule

// File: rtl/amclk_bit_tick.sv
module amclk_bit_tick #(
  parameter int FRAME_512    = 1024,
  parameter int FRAME_384    = 768,
  parameter int SLOTS_NARROW = 64,
  parameter int SLOTS_WIDE   = 96,
  parameter int POS_W        = $clog2(FRAME_512)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on,
  input  logic clear,
  input  logic base384,
  input  logic wide,
  output logic tick
);
  localparam int AW = POS_W + 1;

  logic [AW-1:0]    frame_len;
  logic [AW-1:0]    step;
  logic [AW-1:0]    sum;
  logic [AW-1:0]    nxt;
  logic [POS_W-1:0] acc;

  assign frame_len = base384 ? AW'(FRAME_384)  : AW'(FRAME_512);
  assign step      = wide    ? AW'(SLOTS_WIDE) : AW'(SLOTS_NARROW);
  assign sum       = {1'b0, acc} + step;
  assign nxt       = (sum >= frame_len) ? (sum - frame_len) : sum;

  // acc holds (position * step) mod frame length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else            acc <= nxt[POS_W-1:0];
  end

  assign tick = on && ({1'b0, acc} < step);
endmodule

// File: rtl/amclk_edge_sync.sv
module amclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign rise =  sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/audio_mclk_gen.sv
module audio_mclk_gen
  import amclk_pkg::*;
#(
  parameter int FRAME_512    = 1024,
  parameter int FRAME_384    = 768,
  parameter int SLOTS_NARROW = 64,
  parameter int SLOTS_WIDE   = 96,
  parameter int MAX_CODE_512 = 4,
  parameter int MAX_CODE_384 = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  base384,
  input  logic [AMC_CODE_W-1:0] mult_code,
  input  logic                  wide_slot,
  input  logic                  slave,
  input  logic                  ext_bclk,
  input  logic                  ext_lrclk,
  output logic                  mclk,
  output logic                  bclk_tick,
  output logic                  lr_tick
);
  localparam int POS_W = $clog2(FRAME_512);
  localparam int NPIN  = 2;

  amc_cfg_t              cfg_in;
  amc_cfg_t              cfg_q;
  logic [AMC_CODE_W-1:0] eff_code;
  logic                  on_q;
  logic [POS_W-1:0]      pos;
  logic                  wrap;
  logic                  slot_start;
  logic                  int_tick;
  logic [NPIN-1:0]       pins;
  logic [NPIN-1:0]       pin_rise;
  logic [NPIN-1:0]       pin_fall;

  assign cfg_in = '{base384: base384, code: mult_code, wide: wide_slot};

  // settings load while idle and at the last position of every frame
  amclk_cfg_hold #(
    .MAX_CODE_512(MAX_CODE_512),
    .MAX_CODE_384(MAX_CODE_384)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (!on_q || wrap),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q),
    .eff_code(eff_code)
  );

  amclk_frame_ctr #(
    .FRAME_512(FRAME_512),
    .FRAME_384(FRAME_384),
    .POS_W    (POS_W)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .base384   (cfg_q.base384),
    .on_q      (on_q),
    .pos       (pos),
    .wrap      (wrap),
    .slot_start(slot_start)
  );

  amclk_bit_tick #(
    .FRAME_512   (FRAME_512),
    .FRAME_384   (FRAME_384),
    .SLOTS_NARROW(SLOTS_NARROW),
    .SLOTS_WIDE  (SLOTS_WIDE),
    .POS_W       (POS_W)
  ) u_btick (
    .clk    (clk),
    .rst_n  (rst_n),
    .on     (on_q),
    .clear  (!on_q || wrap),
    .base384(cfg_q.base384),
    .wide   (cfg_q.wide),
    .tick   (int_tick)
  );

  assign pins = {ext_lrclk, ext_bclk};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    amclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pins[g]),
      .rise (pin_rise[g]),
      .fall (pin_fall[g])
    );
  end

  // The select only moves at position 0, where every candidate bit is low
  assign mclk      = on_q && pos[eff_code];
  assign bclk_tick = on_q && (slave ? pin_rise[0] : int_tick);
  assign lr_tick   = on_q && (slave ? (pin_rise[1] | pin_fall[1]) : slot_start);
endmodule

// File: rtl/amclk_chk.sv
module amclk_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic slave,
  input logic mclk,
  input logic bclk_tick,
  input logic lr_tick
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!mclk && !bclk_tick && !lr_tick));

  // R1
  mclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclk |-> $past(run));

  // R10
  start_slot_chk: assert property (@(posedge clk) disable iff (!rst_n || slave)
    $rose(run) |=> lr_tick);

  // R5
  lr_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n || slave)
    lr_tick |-> bclk_tick);

  // R5
  bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n || slave)
    bclk_tick |=> !bclk_tick);

  // R6
  lr_single_chk: assert property (@(posedge clk) disable iff (!rst_n || slave)
    lr_tick |=> !lr_tick);
endmodule

bind audio_mclk_gen amclk_chk u_amclk_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .slave    (slave),
  .mclk     (mclk),
  .bclk_tick(bclk_tick),
  .lr_tick  (lr_tick)
);

// File: tb/tb_audio_mclk_gen.sv
`timescale 1ns/1ps
module tb_audio_mclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       base384 = 1'b0;
  logic [2:0] mult_code = 3'd0;
  logic       wide_slot = 1'b0;
  logic       slave = 1'b0;
  logic       ext_bclk = 1'b0;
  logic       ext_lrclk = 1'b0;
  logic       mclk;
  logic       bclk_tick;
  logic       lr_tick;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  audio_mclk_gen dut (
    .clk(clk), .rst_n(rst_n), .run(run), .base384(base384),
    .mult_code(mult_code), .wide_slot(wide_slot), .slave(slave),
    .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk),
    .mclk(mclk), .bclk_tick(bclk_tick), .lr_tick(lr_tick)
  );

  function automatic int frame_of(input int b);
    return b ? 768 : 1024;
  endfunction

  function automatic int eff_of(input int b, input int c);
    if (b) return (c > 3) ? 0 : c;
    return (c > 4) ? 0 : c;
  endfunction

  task automatic chk(input bit got, input bit exp, input string tag, input string what);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // compare all three outputs at frame position p
  task automatic check_pos(input int p, input int b, input int c, input int w,
                           input string mtag, input string btag, input string ltag);
    int f;
    int s;
    f = frame_of(b);
    s = w ? 96 : 64;
    chk(mclk, ((p >> eff_of(b, c)) & 1) == 1, mtag, "mclk");
    chk(bclk_tick, ((p * s) % f) < s, btag, "bclk_tick");
    chk(lr_tick, (p == 0) || (p == f / 2), ltag, "lr_tick");
  endtask

  task automatic start_cfg(input int b, input int c, input int w);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    base384   = b[0];
    mult_code = c[2:0];
    wide_slot = w[0];
    run       = 1'b1;
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    string mt;
    repeat (3) @(negedge clk);
    // R1: outputs quiet after reset while run is low
    for (int k = 0; k < 4; k++) begin
      chk(mclk, 1'b0, "R1", "mclk after reset");
      chk(bclk_tick, 1'b0, "R1", "bclk after reset");
      chk(lr_tick, 1'b0, "R1", "lr after reset");
      @(negedge clk);
    end
    rst_n = 1'b1;
    base384 = 1'b1;
    mult_code = 3'd2;
    repeat (3) @(negedge clk);
    chk(mclk, 1'b0, "R1", "mclk idle");
    chk(lr_tick, 1'b0, "R1", "lr idle");

    // R2 R3 R4 R5 R6 R10: sweep every base, code and slot width
    for (int b = 0; b < 2; b++) begin
      for (int w = 0; w < 2; w++) begin
        for (int c = 0; c < 8; c++) begin
          if (c > (b ? 3 : 4)) mt = "R4";
          else                 mt = b ? "R3" : "R2";
          start_cfg(b, c, w);
          for (int p = 0; p < frame_of(b); p++) begin
            @(negedge clk);
            check_pos(p, b, c, w, mt, "R5", (p == 0) ? "R10" : "R6");
          end
        end
      end
    end

    // R7: mid-frame changes apply only from the next frame
    start_cfg(0, 0, 0);
    for (int p = 0; p < 1024; p++) begin
      @(negedge clk);
      check_pos(p, 0, 0, 0, "R7", "R7", "R7");
      if (p == 100) mult_code = 3'd2;
    end
    for (int p = 0; p < 1024; p++) begin
      @(negedge clk);
      check_pos(p, 0, 2, 0, "R7", "R7", "R7");
      if (p == 50) begin
        base384   = 1'b1;
        wide_slot = 1'b1;
      end
    end
    for (int p = 0; p < 768; p++) begin
      @(negedge clk);
      check_pos(p, 1, 2, 1, "R7", "R7", "R7");
    end

    // R9: external pins toggle in master mode without effect
    start_cfg(0, 1, 1);
    for (int p = 0; p < 1024; p++) begin
      @(negedge clk);
      check_pos(p, 0, 1, 1, "R9", "R9", "R9");
      ext_bclk  = p[0];
      ext_lrclk = p[1];
    end

    // R1: dropping run silences the outputs on the next cycle
    run = 1'b0;
    ext_bclk  = 1'b0;
    ext_lrclk = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(mclk, 1'b0, "R1", "mclk after stop");
      chk(bclk_tick, 1'b0, "R1", "bclk after stop");
      chk(lr_tick, 1'b0, "R1", "lr after stop");
    end

    // R8: slave mode follows the external pins only
    slave = 1'b1;
    base384 = 1'b0;
    wide_slot = 1'b0;
    run = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk(bclk_tick, 1'b0, "R8", "no internal bclk");
      chk(lr_tick, 1'b0, "R8", "no internal lr");
    end
    for (int r = 0; r < 3; r++) begin
      ext_bclk = 1'b1;
      for (int k = 1; k <= 5; k++) begin
        @(negedge clk);
        chk(bclk_tick, k == 2, "R8", "bclk on rise");
        chk(lr_tick, 1'b0, "R8", "lr quiet");
      end
      ext_bclk = 1'b0;
      for (int k = 1; k <= 5; k++) begin
        @(negedge clk);
        chk(bclk_tick, 1'b0, "R8", "bclk on fall");
      end
      ext_lrclk = ~ext_lrclk;
      for (int k = 1; k <= 5; k++) begin
        @(negedge clk);
        chk(lr_tick, k == 2, "R8", "lr on edge");
        chk(bclk_tick, 1'b0, "R8", "bclk quiet");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule